// File: doc/BRIEF.md
# Multiplexed Address/Data Host-Bus Master

This block is a bus master. It turns single read and write requests from inside the chip into cycles on an external host bus, where the low-order address and the data share one set of pins. Each cycle has two parts. First comes an address phase, in which the shared pins carry the low address while the latch strobe (ALE) is high. Then comes a data phase, in which the same pins carry write data, or are released so that the device can drive read data. The upper address bits have dedicated pins of their own and hold steady for the whole cycle.

The chip-select style is picked by two configuration inputs, giving one, two or four active-low selects. The select index comes from the top address bits. In 16-bit mode the block also drives active-low byte-lane selects. A streaming-read option keeps the output enable low across successive reads to the same latched low address and the same chip select. In that case only the dedicated upper address pins change between reads, which lets an SRAM be read back to back without new address phases.

Top module: `mux_hostbus_master`

## Requirements
- R1: After a request is accepted, the first bus phase lasts ADDR_CYC cycles (default 1). In it, hb_ale is 1, hb_ad_oe is 1 and hb_ad_o carries req_addr[DW-1:0]. The data phase of DATA_CYC cycles (default 2) follows directly, with hb_ale at 0.
- R2: hb_addr_hi carries req_addr[AW-1:DW] from the first address-phase cycle until the cycle ends, and keeps that value until the next request is accepted.
- R3: In a write, hb_wrn is 0 for exactly the DATA_CYC data-phase cycles and never while hb_ale is 1. During those cycles hb_ad_oe is 1 and hb_ad_o carries req_wdata.
- R4: The chip-select mode is decoded from cfg_cs_ext and cfg_cs_sel:
  - cfg_cs_ext=0 with cfg_cs_sel=3 gives dual mode, where req_addr[AW-1] picks hb_csn[0] or hb_csn[1].
  - cfg_cs_ext=1 with cfg_cs_sel=2 gives quad mode, where req_addr[AW-1:AW-2] picks hb_csn[index].
  - Any other value gives single mode, which uses hb_csn[0] only.
  - At most one hb_csn bit is low at any time.
- R5: In dual or quad mode, the selected chip select goes low in the same cycle as hb_ale rises. In single mode, hb_csn[0] stays high during the address phase and goes low in the first data-phase cycle.
- R6: With cfg_wide=1, hb_bseln equals ~req_be for the whole cycle, where bit 0 is the low byte lane. With cfg_wide=0, hb_bseln stays 2'b11.
- R7: In a read, hb_oen is 0 and hb_ad_oe is 0 through the data phase. hb_ad_i is sampled at the end of the last data-phase cycle. rsp_valid is 1 for one cycle in the next cycle, with rsp_rdata holding the sampled word.
- R8: After a read cycle ends, one turnaround cycle follows in which hb_ale=0, hb_oen=1, all hb_csn bits are 1 and hb_ad_oe=0. Only after that can a new address phase start.
- R9: With cfg_stream=1, a pending read whose low address and chip-select index match the current read is accepted in the last data cycle, with req_ready=1. It then runs a new data phase with no hb_ale pulse. hb_oen and the chip select stay low, and only hb_addr_hi changes.
- R10: If the streaming conditions are not met, the next request waits for the turnaround and the idle cycle. This applies when cfg_stream=0, when the low address or the chip select differs, or when the request is a write.
- R11: req_ready is 1 in idle and low while a cycle is running, except in the streaming case of R9. A request is taken on a cycle with req_valid=1 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cs_ext | input | 1 | Chip-select extension bit |
| cfg_cs_sel | input | 2 | Chip-select style field |
| cfg_wide | input | 1 | 1 = 16-bit data with byte selects, 0 = 8-bit |
| cfg_stream | input | 1 | Enables streaming reads |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Read data |
| hb_ale | output | 1 | Address latch enable |
| hb_csn | output | 4 | Active-low chip selects |
| hb_wrn | output | 1 | Active-low write strobe |
| hb_oen | output | 1 | Active-low read / output enable |
| hb_bseln | output | DW/8 | Active-low byte selects |
| hb_addr_hi | output | AW-DW | Dedicated upper address pins |
| hb_ad_o | output | DW | Shared pins, output value |
| hb_ad_oe | output | 1 | Shared pins, output enable |
| hb_ad_i | input | DW | Shared pins, input value |

## Verification
The hardest situation to reach from the ports is the streaming handoff. Two reads must already overlap, and the second one has to be presented while the first is still in its data phase. The bench therefore holds req_valid high with the follow-on read right after the first is accepted. It then checks that req_ready rises only in the last data cycle and that no ALE pulse appears. A mirror case changes the low address by one, so the same overlap has to fall back to the turnaround path. A small SRAM model latches the low address on ALE and returns data computed from the full address, so each returned word shows which address was actually on the pins.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_TURN = 2'd3
  } hbm_state_e;

  typedef enum logic [1:0] {
    CSM_SINGLE = 2'd0,
    CSM_DUAL   = 2'd1,
    CSM_QUAD   = 2'd2
  } hbm_csmode_e;

  // Chip-select style from the configuration pair.
  function automatic hbm_csmode_e cs_mode(input logic ext, input logic [1:0] sel);
    if (!ext && sel == 2'd3)     return CSM_DUAL;
    else if (ext && sel == 2'd2) return CSM_QUAD;
    else                         return CSM_SINGLE;
  endfunction

  // Chip-select index from the two top address bits.
  function automatic logic [1:0] cs_index(input hbm_csmode_e m, input logic [1:0] top);
    case (m)
      CSM_DUAL: return {1'b0, top[1]};
      CSM_QUAD: return top;
      default:  return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/hbm_seq.sv
module hbm_seq
  import hbm_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int NB       = 2,
  parameter int ADDR_CYC = 1,
  parameter int DATA_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [NB-1:0]     req_be,
  input  logic              cfg_stream,
  input  hbm_csmode_e       mode,
  input  logic [DW-1:0]     bus_in,
  output logic              req_ready,
  output hbm_state_e        state,
  output logic              cur_write,
  output logic [AW-1:0]     cur_addr,
  output logic [DW-1:0]     cur_wdata,
  output logic [NB-1:0]     cur_be,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);

  localparam int MAXC = (ADDR_CYC > DATA_CYC) ? ADDR_CYC : DATA_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_CYC - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_CYC - 1);

  hbm_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            wr_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [NB-1:0]   be_q;
  logic            rsp_v_q, rsp_v_d;
  logic [DW-1:0]   rdata_q;
  logic            addr_last, data_last, stream_ok, fire, sample_en;

  assign addr_last = (state_q == ST_ADDR) && (cnt_q == ADDR_LAST);
  assign data_last = (state_q == ST_DATA) && (cnt_q == DATA_LAST);

  // A follow-on read may ride the open output enable.
  assign stream_ok = cfg_stream && !wr_q && !req_write &&
                     (req_addr[DW-1:0] == addr_q[DW-1:0]) &&
                     (cs_index(mode, req_addr[AW-1:AW-2]) == cs_index(mode, addr_q[AW-1:AW-2]));

  assign req_ready = (state_q == ST_IDLE) || (data_last && stream_ok);
  assign fire      = req_valid && req_ready;
  assign sample_en = data_last && !wr_q;
  assign rsp_v_d   = sample_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (fire) begin
          state_d = ST_ADDR;
          cnt_d   = '0;
        end
      end
      ST_ADDR: begin
        if (addr_last) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_DATA: begin
        if (data_last) begin
          cnt_d = '0;
          if (fire)      state_d = ST_DATA;
          else if (wr_q) state_d = ST_IDLE;
          else           state_d = ST_TURN;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rsp_v_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rsp_v_q <= rsp_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (fire) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (sample_en) rdata_q <= bus_in;
  end

  assign state     = state_q;
  assign cur_write = wr_q;
  assign cur_addr  = addr_q;
  assign cur_wdata = wdata_q;
  assign cur_be    = be_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rdata_q;

  // R2: the captured address only moves when a request is taken.
  p_hi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !fire) |=> $stable(addr_q));

  // R7: a response only follows a read data phase.
  p_rsp_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_v_q |-> $past(state_q == ST_DATA && !wr_q));

  // R11: acceptance while busy only on the streaming path.
  p_busy_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && state_q != ST_IDLE) |-> (state_q == ST_DATA && !wr_q && cfg_stream && !req_write));

endmodule

// File: rtl/hbm_csdec.sv
module hbm_csdec
  import hbm_pkg::*;
#(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  hbm_csmode_e    mode,
  input  hbm_state_e     state,
  input  logic [1:0]     idx,
  input  logic           ale,
  output logic [NCS-1:0] csn
);

  logic active;

  // Single select waits for the data phase; dual and quad open with ALE.
  always_comb begin
    if (mode == CSM_SINGLE) active = (state == ST_DATA);
    else                    active = (state == ST_ADDR) || (state == ST_DATA);
  end

  always_comb begin
    csn = '1;
    for (int i = 0; i < NCS; i++) begin
      if (active && (idx == 2'(i))) csn[i] = 1'b0;
    end
  end

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~csn));

  p_cs_with_ale_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && mode != CSM_SINGLE) |-> (csn != '1));

  p_cs_after_ale_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && mode == CSM_SINGLE) |-> (csn == '1));

endmodule

// File: rtl/hbm_lanes.sv
module hbm_lanes
  import hbm_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hbm_state_e       state,
  input  logic             cur_write,
  input  logic [AW-1:0]    cur_addr,
  input  logic [DW-1:0]    cur_wdata,
  input  logic [NB-1:0]    cur_be,
  input  logic             cfg_wide,
  output logic             ale,
  output logic             wrn,
  output logic             oen,
  output logic [NB-1:0]    bseln,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe
);

  logic in_addr, in_data, in_cycle;

  assign in_addr  = (state == ST_ADDR);
  assign in_data  = (state == ST_DATA);
  assign in_cycle = in_addr || in_data;

  assign ale     = in_addr;
  assign wrn     = !(in_data && cur_write);
  assign oen     = !(in_data && !cur_write);
  assign addr_hi = cur_addr[AW-1:DW];

  always_comb begin
    ad_o  = '0;
    ad_oe = 1'b0;
    if (in_addr) begin
      ad_o  = cur_addr[DW-1:0];
      ad_oe = 1'b1;
    end else if (in_data && cur_write) begin
      ad_o  = cur_wdata;
      ad_oe = 1'b1;
    end
  end

  assign bseln = (cfg_wide && in_cycle) ? ~cur_be : '1;

  p_wr_no_ale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrn |-> (!ale && ad_oe));

  p_bsel_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wide |-> (bseln == '1));

  p_rd_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oen |-> (!ad_oe && wrn));

  p_turn_before_ale_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(oen));

endmodule

// File: rtl/mux_hostbus_master.sv
module mux_hostbus_master
  import hbm_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int ADDR_CYC = 1,
  parameter int DATA_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_cs_ext,
  input  logic [1:0]          cfg_cs_sel,
  input  logic                cfg_wide,
  input  logic                cfg_stream,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [DW/8-1:0]     req_be,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic                hb_ale,
  output logic [3:0]          hb_csn,
  output logic                hb_wrn,
  output logic                hb_oen,
  output logic [DW/8-1:0]     hb_bseln,
  output logic [AW-DW-1:0]    hb_addr_hi,
  output logic [DW-1:0]       hb_ad_o,
  output logic                hb_ad_oe,
  input  logic [DW-1:0]       hb_ad_i
);

  localparam int NB = DW / 8;

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  hbm_csmode_e    mode;
  hbm_state_e     state;
  logic           cur_write;
  logic [AW-1:0]  cur_addr;
  logic [DW-1:0]  cur_wdata;
  logic [NB-1:0]  cur_be;
  logic [1:0]     cur_idx;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode    = cs_mode(cfg_cs_ext, cfg_cs_sel);
  assign cur_idx = cs_index(mode, cur_addr[AW-1:AW-2]);

  hbm_seq #(
    .AW(AW), .DW(DW), .NB(NB), .ADDR_CYC(ADDR_CYC), .DATA_CYC(DATA_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .cfg_stream (cfg_stream),
    .mode       (mode),
    .bus_in     (hb_ad_i),
    .req_ready  (req_ready),
    .state      (state),
    .cur_write  (cur_write),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .cur_be     (cur_be),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  hbm_lanes #(
    .AW(AW), .DW(DW), .NB(NB)
  ) u_lanes (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state     (state),
    .cur_write (cur_write),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .cur_be    (cur_be),
    .cfg_wide  (cfg_wide),
    .ale       (hb_ale),
    .wrn       (hb_wrn),
    .oen       (hb_oen),
    .bseln     (hb_bseln),
    .addr_hi   (hb_addr_hi),
    .ad_o      (hb_ad_o),
    .ad_oe     (hb_ad_oe)
  );

  hbm_csdec #(
    .NCS(4)
  ) u_csdec (
    .clk   (clk),
    .rst_n (rst_int_n),
    .mode  (mode),
    .state (state),
    .idx   (cur_idx),
    .ale   (hb_ale),
    .csn   (hb_csn)
  );

endmodule

// File: tb/sim_mux_hostbus_master.sv
`timescale 1ns/1ps
module sim_mux_hostbus_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cs_ext = 1'b0;
  logic [1:0]  cfg_cs_sel = 2'd0;
  logic        cfg_wide = 1'b1;
  logic        cfg_stream = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        hb_ale;
  logic [3:0]  hb_csn;
  logic        hb_wrn;
  logic        hb_oen;
  logic [1:0]  hb_bseln;
  logic [3:0]  hb_addr_hi;
  logic [15:0] hb_ad_o;
  logic        hb_ad_oe;
  logic [15:0] hb_ad_i;
  logic [15:0] lat_lo = '0;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  mux_hostbus_master #(.AW(20), .DW(16), .ADDR_CYC(1), .DATA_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cs_ext(cfg_cs_ext), .cfg_cs_sel(cfg_cs_sel),
    .cfg_wide(cfg_wide), .cfg_stream(cfg_stream), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .hb_ale(hb_ale), .hb_csn(hb_csn), .hb_wrn(hb_wrn),
    .hb_oen(hb_oen), .hb_bseln(hb_bseln), .hb_addr_hi(hb_addr_hi),
    .hb_ad_o(hb_ad_o), .hb_ad_oe(hb_ad_oe), .hb_ad_i(hb_ad_i)
  );

  // SRAM model behind an address latch.
  function automatic logic [15:0] mem_fn(input logic [19:0] a);
    return a[15:0] ^ {4{a[19:16]}} ^ 16'h5A3C;
  endfunction

  always @(posedge clk) if (hb_ale) lat_lo <= hb_ad_o;
  assign hb_ad_i = mem_fn({hb_addr_hi, lat_lo});

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 ready after reset", req_ready, 1);
    chk("R1 ale idle", hb_ale, 0);
    chk("R4 csn idle", hb_csn, 4'hF);
    chk("R3 wrn idle", hb_wrn, 1);
    chk("R7 oen idle", hb_oen, 1);
    chk("R7 rsp idle", rsp_valid, 0);
    chk("R6 bsel idle", hb_bseln, 2'b11);
  endtask

  // Single chip select, 16-bit write with the low lane only.
  task automatic t_write_single();
    cfg_cs_ext = 0; cfg_cs_sel = 2'd0; cfg_wide = 1; cfg_stream = 0;
    req_write = 1; req_addr = 20'h5_1234; req_wdata = 16'hBEEF; req_be = 2'b01;
    req_valid = 1;
    chk("R11 ready idle", req_ready, 1);
    step();
    req_valid = 0;
    chk("R1 ale addr phase", hb_ale, 1);
    chk("R1 ad addr", hb_ad_o, 16'h1234);
    chk("R1 ad_oe addr", hb_ad_oe, 1);
    chk("R5 single cs late", hb_csn, 4'hF);
    chk("R3 wrn not with ale", hb_wrn, 1);
    chk("R2 addr_hi", hb_addr_hi, 4'h5);
    chk("R6 bsel wide", hb_bseln, 2'b10);
    step();
    chk("R1 ale off data", hb_ale, 0);
    chk("R3 wrn data1", hb_wrn, 0);
    chk("R3 wdata", hb_ad_o, 16'hBEEF);
    chk("R5 single cs data", hb_csn, 4'hE);
    chk("R2 addr_hi data", hb_addr_hi, 4'h5);
    chk("R11 busy not ready", req_ready, 0);
    step();
    chk("R3 wrn data2", hb_wrn, 0);
    chk("R6 bsel held", hb_bseln, 2'b10);
    step();
    chk("R3 wrn end", hb_wrn, 1);
    chk("R4 cs released", hb_csn, 4'hF);
    chk("R11 ready after write", req_ready, 1);
  endtask

  // Dual mode read, top bit set picks select 1.
  task automatic t_read_dual();
    cfg_cs_ext = 0; cfg_cs_sel = 2'd3; cfg_wide = 1; cfg_stream = 0;
    req_write = 0; req_addr = 20'h8_00F0; req_be = 2'b11; req_valid = 1;
    step();
    req_valid = 0;
    chk("R5 dual cs with ale", {hb_ale, hb_csn}, {1'b1, 4'hD});
    step();
    chk("R7 oen low", hb_oen, 0);
    chk("R7 pins released", hb_ad_oe, 0);
    chk("R4 dual cs1", hb_csn, 4'hD);
    step();
    chk("R7 oen low 2", hb_oen, 0);
    step();
    chk("R8 turn oen", hb_oen, 1);
    chk("R8 turn cs", hb_csn, 4'hF);
    chk("R8 turn ale", hb_ale, 0);
    chk("R8 turn oe", hb_ad_oe, 0);
    chk("R7 rsp valid", rsp_valid, 1);
    chk("R7 rsp data", rsp_rdata, mem_fn(20'h8_00F0));
    chk("R8 not ready in turn", req_ready, 0);
    step();
    chk("R7 rsp pulse", rsp_valid, 0);
    chk("R11 ready idle", req_ready, 1);
  endtask

  // Quad mode write in 8-bit mode, then a non-matching config.
  task automatic t_quad_write();
    cfg_cs_ext = 1; cfg_cs_sel = 2'd2; cfg_wide = 0; cfg_stream = 0;
    req_write = 1; req_addr = 20'hC_0042; req_wdata = 16'h00AA; req_be = 2'b01;
    req_valid = 1;
    step();
    req_valid = 0;
    chk("R5 quad cs with ale", {hb_ale, hb_csn}, {1'b1, 4'h7});
    chk("R6 narrow bsel", hb_bseln, 2'b11);
    step();
    chk("R4 quad cs3", hb_csn, 4'h7);
    chk("R6 narrow bsel data", hb_bseln, 2'b11);
    step(); step();
    cfg_cs_ext = 1; cfg_cs_sel = 2'd3;
    req_addr = 20'h4_0042; req_valid = 1;
    step();
    req_valid = 0;
    chk("R4 other cfg single", hb_csn, 4'hF);
    step();
    chk("R4 other cfg cs0", hb_csn, 4'hE);
    step(); step();
  endtask

  // Two reads back to back with streaming off.
  task automatic t_back_to_back();
    cfg_cs_ext = 0; cfg_cs_sel = 2'd3; cfg_wide = 1; cfg_stream = 0;
    req_write = 0; req_addr = 20'h1_0456; req_valid = 1;
    step();
    req_addr = 20'h3_0456;
    step();
    step();
    chk("R10 no stream when off", req_ready, 0);
    step();
    chk("R10 turn first", {hb_ale, hb_oen}, {1'b0, 1'b1});
    chk("R7 rsp A", rsp_rdata, mem_fn(20'h1_0456));
    step();
    chk("R8 idle before ale", {hb_ale, req_ready}, {1'b0, 1'b1});
    step();
    req_valid = 0;
    chk("R1 second ale", hb_ale, 1);
    chk("R1 second addr", hb_ad_o, 16'h0456);
    step(); step(); step();
    chk("R7 rsp B", {rsp_valid, rsp_rdata}, {1'b1, mem_fn(20'h3_0456)});
  endtask

  // Streaming read follow-on with matching low address and select.
  task automatic t_stream();
    cfg_cs_ext = 0; cfg_cs_sel = 2'd3; cfg_wide = 1; cfg_stream = 1;
    req_write = 0; req_addr = 20'h1_0456; req_valid = 1;
    step();
    req_addr = 20'h3_0456;
    chk("R1 stream first ale", hb_ale, 1);
    step();
    chk("R9 not ready mid data", req_ready, 0);
    step();
    chk("R9 ready last cycle", req_ready, 1);
    chk("R9 oen low", hb_oen, 0);
    step();
    req_valid = 0;
    chk("R9 no ale", hb_ale, 0);
    chk("R9 oen held", hb_oen, 0);
    chk("R9 cs held", hb_csn, 4'hE);
    chk("R9 addr_hi moved", hb_addr_hi, 4'h3);
    chk("R7 stream rsp A", {rsp_valid, rsp_rdata}, {1'b1, mem_fn(20'h1_0456)});
    step();
    chk("R9 still no ale", {hb_ale, hb_oen}, {1'b0, 1'b0});
    step();
    chk("R9 stream rsp B", {rsp_valid, rsp_rdata}, {1'b1, mem_fn(20'h3_0456)});
    chk("R8 turn after stream", hb_oen, 1);
    step();
  endtask

  // Streaming on, but the low address differs by one.
  task automatic t_stream_break();
    cfg_cs_ext = 0; cfg_cs_sel = 2'd3; cfg_wide = 1; cfg_stream = 1;
    req_write = 0; req_addr = 20'h1_0456; req_valid = 1;
    step();
    req_addr = 20'h3_0457;
    step(); step();
    chk("R10 mismatch not ready", req_ready, 0);
    step();
    chk("R10 mismatch turn", hb_oen, 1);
    step();
    step();
    req_valid = 0;
    chk("R10 new ale", {hb_ale, hb_ad_o}, {1'b1, 16'h0457});
    step(); step(); step();
    chk("R7 rsp C", rsp_rdata, mem_fn(20'h3_0457));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_write_single();
    step();
    t_read_dual();
    t_quad_write();
    step();
    t_back_to_back();
    step(); step();
    t_stream();
    step();
    t_stream_break();
    step(); step();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule